// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a DMA channel. Incoming frame bytes arrive on a byte stream that marks its final byte. They are stored into host buffers, and those buffers are described by a ring of two-word descriptors in shared memory. Software first loads the ring base through a small register port. It then arms each slot by writing the buffer address and a flags word. The flags word carries an ownership bit and the usable buffer size. When a frame begins, the block fetches the current slot's flags and then its buffer address. It stores the bytes one at a time with byte enables, writes the received byte count back with ownership cleared, and steps to the next slot.

If the current slot is not armed, the frame is consumed and discarded. A drop flag is raised, and the slot is used again for the next frame. If a frame is longer than the armed size, it is cut to that size and a separate flag records the truncation. The status bits stay set until written one-to-clear. A mask register gates which of them reach the interrupt line. A control bit performs a channel-local soft reset that clears itself.

Top module: `rx_ring_writer`

## Requirements
- R1: The descriptor for slot k sits at word addresses base+2k (flags) and base+2k+1 (buffer byte address). In the flags word, bit 31 is the ownership bit (1 = device may fill) and bits 15:0 hold the size or length. Byte i of a frame is stored at buffer byte address addr+i, inside word (addr+i)>>2, on byte lane (addr+i)&3.
- R2: When a frame starts on a slot whose ownership bit is 0, the whole frame is accepted and discarded. No memory write takes place, the descriptor is left unchanged, status bit 1 (drop) is set, and the slot index does not advance.
- R3: When a frame completes on an owned slot, the flags word is rewritten with ownership 0 and a length equal to the number of bytes stored. That count includes the trailing 4 FCS bytes carried on the stream. Nothing in the buffer past that length is modified.
- R4: A frame longer than the armed size has only its first size bytes stored. The reported length is then that size, and status bit 2 (too-small) is set.
- R5: Each completed reception sets status bit 0 (received). The interrupt output is high whenever a status bit is set and its bit in the mask register (register 2) is 0.
- R6: After each completed reception the slot index advances by one. It wraps from the last slot (2^RING_LOG2 - 1) back to slot 0.
- R7: Writing 1 to bit 0 of the control register (register 1) clears the slot index and all status bits. The reset bit clears itself on the next cycle.
- R8: Writing register 3 clears every status bit whose data bit is 1. Register 0 holds the ring base as a word address.
- R9: Memory reads return data on mem_rdata one cycle after the request. Every buffer write enables exactly one byte lane and replicates the data byte on all four lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 control, 2 mask, 3 status clear |
| reg_wdata | input | 32 | Register write data |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | AW | Memory word address |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |
| rx_status | output | 3 | Status: bit 0 received, bit 1 dropped, bit 2 truncated |
| rx_irq | output | 1 | Unmasked status interrupt |

## Verification
A wrong slot index shows up within one frame. The next frame's bytes and its length word land in the wrong descriptor and buffer, and a bench that tracks the index independently finds the expected descriptor untouched. A wrong byte count or a lost truncation state shows up in the written-back length and in the too-small bit three cycles after the last byte. An ownership decision taken from stale read data either corrupts an unarmed buffer or drops a frame that should have been stored, and the drop bit shows this as soon as the last byte is accepted.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW        = 16,
  parameter int RING_LOG2 = 2,
  parameter int LEN_W     = 16,
  parameter int OWN_BIT   = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [2:0]    rx_status,
  output logic          rx_irq
);
  localparam int BW = AW + 2;

  typedef enum logic [2:0] {S_IDLE, S_RDF, S_CHKF, S_ADDR, S_DATA, S_DROP, S_WB} st_t;

  st_t                  st;
  logic [AW-1:0]        base;
  logic [2:0]           mask, status, set_bits, clr_bits;
  logic                 srst;
  logic [RING_LOG2-1:0] idx;
  logic [LEN_W-1:0]     size, cnt;
  logic [BW-1:0]        buf_a;

  wire [AW-1:0] desc_a = base + AW'({idx, 1'b0});
  wire [BW-1:0] byte_a = buf_a + BW'(cnt);
  wire          fits   = cnt < size;
  wire          accept = s_valid && s_ready;
  wire          own    = mem_rdata[OWN_BIT];
  wire          unused_bits = ^{mem_rdata, reg_wdata};

  assign s_ready   = (st == S_DATA) || (st == S_DROP);
  assign rx_status = status;
  assign rx_irq    = |(status & ~mask);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_a;
    mem_be    = 4'h0;
    mem_wdata = {4{s_data}};
    case (st)
      S_RDF:  mem_req = 1'b1;
      S_CHKF: begin mem_req = own; mem_addr = desc_a + AW'(1); end
      S_DATA: begin
        mem_req  = accept && fits;
        mem_we   = 1'b1;
        mem_addr = byte_a[BW-1:2];
        mem_be   = 4'b0001 << byte_a[1:0];
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'hF;
        mem_wdata = 32'(cnt);
      end
      default: ;
    endcase
  end

  always_comb begin
    set_bits = 3'b000;
    if (st == S_WB) set_bits[0] = 1'b1;
    if (st == S_DROP && accept && s_last) set_bits[1] = 1'b1;
    if (st == S_DATA && accept && !fits) set_bits[2] = 1'b1;
    clr_bits = (reg_we && reg_addr == 2'd3) ? reg_wdata[2:0] : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; base <= '0; mask <= '0; status <= '0; srst <= 1'b0;
      idx <= '0; size <= '0; cnt <= '0; buf_a <= '0;
    end else if (srst) begin
      st <= S_IDLE; status <= '0; idx <= '0; srst <= 1'b0;
    end else begin
      status <= (status & ~clr_bits) | set_bits;
      if (reg_we) begin
        case (reg_addr)
          2'd0: base <= reg_wdata[AW-1:0];
          2'd1: srst <= reg_wdata[0];
          2'd2: mask <= reg_wdata[2:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (s_valid) st <= S_RDF;
        S_RDF:  st <= S_CHKF;
        S_CHKF: begin
          size <= mem_rdata[LEN_W-1:0];
          st   <= own ? S_ADDR : S_DROP;
        end
        S_ADDR: begin buf_a <= mem_rdata[BW-1:0]; cnt <= '0; st <= S_DATA; end
        S_DATA: if (accept) begin
          if (fits) cnt <= cnt + 1'b1;
          if (s_last) st <= S_WB;
        end
        S_DROP: if (accept && s_last) st <= S_IDLE;
        S_WB:   begin idx <= idx + 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_one_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && mem_req) |-> ($countones(mem_be) == 1 && mem_we));
  p_no_write_on_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DROP) |-> !mem_req);
  p_trunc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && mem_req) |-> (cnt < size));
  p_wb_gives_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB) |-> (mem_req && mem_we && !mem_wdata[OWN_BIT]));
  p_done_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB && !srst) |=> status[0]);
  p_soft_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!srst && idx == '0 && status == 3'b000 && st == S_IDLE));
  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |-> (idx == $past(idx) + 1'b1 || idx == '0));
endmodule

// File: tb/rx_ring_writer_tb_top.sv
module rx_ring_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_W = 16;
  // {armed, size, len}
  localparam logic [16:0] VEC [0:6] = '{
    {1'b1, 8'd64, 8'd64}, {1'b1, 8'd64, 8'd10}, {1'b1, 8'd8, 8'd20},
    {1'b0, 8'd64, 8'd12}, {1'b1, 8'd64, 8'd12}, {1'b1, 8'd64, 8'd1},
    {1'b1, 8'd64, 8'd30}};

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [1:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic s_valid = 0, s_last = 0; logic [7:0] s_data = 0;
  logic s_ready, mem_req, mem_we, rx_irq;
  logic [15:0] mem_addr; logic [3:0] mem_be; logic [31:0] mem_wdata, mem_rdata;
  logic [2:0] rx_status;
  logic tb_we = 0; logic [7:0] tb_a = 0; logic [31:0] tb_d = 0;
  logic [31:0] mem [0:255];
  int tests = 0, fails = 0, eidx = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_writer dut_i (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .s_valid, .s_data,
    .s_last, .s_ready, .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_rdata,
    .rx_status, .rx_irq);

  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++) if (mem_be[b]) mem[mem_addr[7:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  function automatic logic [7:0] get_byte(int ba);
    return mem[ba >> 2][8*(ba & 3) +: 8];
  endfunction

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed * 16 + i * 3 + 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(int a, logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_a = 8'(a); tb_d = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic reg_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic send(int len, int seed);
    for (int i = 0; i < len; i++) begin
      s_valid = 1; s_data = pat(seed, i); s_last = (i == len - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 0; s_last = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic arm(int slot, bit armed, int size);
    poke(BASE_W + 2*slot + 1, 32'h100 + slot * 32'h80);
    for (int w = 0; w < 18; w++) poke(64 + 32*slot + w, 32'hEEEE_EEEE);
    poke(BASE_W + 2*slot, (armed ? 32'h8000_0000 : 32'h0) | 32'(size));
  endtask

  task automatic run_frame(bit armed, int size, int len, int seed);
    int n, bad, ba;
    n = (len < size) ? len : size;
    ba = 32'h100 + eidx * 32'h80;
    arm(eidx, armed, size);
    send(len, seed);
    if (armed) begin
      check("R3 length written back, ownership cleared", mem[BASE_W + 2*eidx], 32'(n));
      bad = 0;
      for (int i = 0; i < n; i++) if (get_byte(ba + i) !== pat(seed, i)) bad++;
      check("R1 buffer bytes placed at address+i", 32'(bad), 0);
      check(len > size ? "R4 byte past size untouched" : "R3 byte past length untouched",
            32'(get_byte(ba + n)), 32'hEE);
      check("R5/R4 status after reception", 32'(rx_status), {29'b0, len > size, 2'b01});
      check("R5 irq with mask 0", 32'(rx_irq), 1);
      eidx = (eidx + 1) % 4;
    end else begin
      check("R2 unowned descriptor unchanged", mem[BASE_W + 2*eidx], 32'(size));
      check("R2 buffer not written", 32'(get_byte(ba)), 32'hEE);
      check("R2 drop status", 32'(rx_status), 32'b010);
    end
    reg_wr(2'd3, 32'h7);
    check("R8 status cleared by write-one", 32'(rx_status), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R5 reset status", 32'(rx_status), 0);
    check("R5 reset irq", 32'(rx_irq), 0);
    check("R9 no request at reset", 32'(mem_req), 0);
    reg_wr(2'd0, BASE_W);
    for (int v = 0; v < 7; v++) begin
      // vectors 5 and 6 land on slots 0 and 1 after wrap: R6
      run_frame(VEC[v][16], int'(VEC[v][15:8]), int'(VEC[v][7:0]), v);
    end
    check("R6 index wrapped to slot 2", 32'(eidx), 2);
    reg_wr(2'd2, 32'h7);
    arm(eidx, 1, 64);
    send(16, 9);
    check("R5 received bit set under mask", 32'(rx_status), 32'b001);
    check("R5 masked irq low", 32'(rx_irq), 0);
    check("R3 masked frame still written back", mem[BASE_W + 2*eidx], 16);
    reg_wr(2'd1, 32'h1);
    @(negedge clk);
    check("R7 soft reset clears status", 32'(rx_status), 0);
    eidx = 0;
    arm(0, 1, 64);
    send(5, 11);
    check("R7 after soft reset frame uses slot 0", mem[BASE_W], 5);
    check("R1 first byte after soft reset", 32'(get_byte(32'h100)), 32'(pat(11, 0)));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule